// File: doc/BRIEF.md
# Accumulator Middle-Word Logic Unit

This execute unit handles the bitwise-logic instruction group of a 16-bit DSP, the group whose instruction word has 0x3 in its top four bits. Each instruction works on the 16-bit middle word of one of two accumulators. The second operand is either the high word of one of two auxiliary registers or the middle word of the other accumulator. The unit decodes the instruction and forms the result. It then issues a write of that result to the destination accumulator's middle word through a dedicated write port, and sets its status flags from the 16-bit result.

Bits 6:0 of every instruction it executes go out on a side channel. A separate unit uses them to run the parallel extension operation. Shift encodings that share the group are not handled here, and neither is any instruction outside the group. Both pass through without a write, without a flag change and without an extension strobe.

The surrounding pipeline supplies the current accumulator middle words and auxiliary high words alongside the instruction. All results appear registered, one clock after the instruction is presented. The write port only carries a middle word, so the low and high words of the destination accumulator are never touched.

Top module: `mwl_top`

## Requirements
- R1: With bits 15:10 = 001100 and bit 7 = 0, the result is the middle word of accumulator d XOR the high word of auxiliary register s. Here d is bit 8 and s is bit 9.
- R2: With bit 7 = 0, bits 15:10 = 001101 give middle(d) AND aux_high(s), and bits 15:10 = 001110 give middle(d) OR aux_high(s).
- R3: With bit 7 = 0 and bits 15:10 = 001111, bit 9 = 0 gives middle(d) AND middle(1-d), and bit 9 = 1 gives middle(d) OR middle(1-d).
- R4: With bit 7 = 1 and bits 15:9 = 0011000, the result is middle(d) XOR middle(1-d).
- R5: With bit 7 = 1 and bits 15:9 = 0011001, the result is the bitwise inverse of middle(d).
- R6: An executed instruction raises `wr_en` for exactly one cycle, on the clock edge after it is presented. At the same time it drives `wr_dst` with instruction bit 8 and `wr_data` with the result.
- R7: An executed instruction sets the flags from the 16-bit result alone. flags[2] (zero) is set when the result is 0, flags[3] (sign) copies result bit 15, and flags[1] (overflow) and flags[0] (carry) are cleared.
- R8: An executed instruction raises `ext_valid` together with `wr_en`, with `ext_field` equal to instruction bits 6:0.
- R9: Certain instructions produce no write and no extension strobe, and leave the flags unchanged. These are the group's shift encodings (bit 7 = 1 with bits 11:9 neither 000 nor 001) and every instruction whose top four bits are not 0011.
- R10: After reset, `wr_en`, `wr_dst`, `wr_data`, `flags`, `ext_valid` and `ext_field` are all 0.
- R11: When `insn_valid` is low, the next cycle has no write and no extension strobe, and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 16 | Instruction word |
| acc_mid0 | input | 16 | Middle word of accumulator 0 |
| acc_mid1 | input | 16 | Middle word of accumulator 1 |
| aux_hi0 | input | 16 | High word of auxiliary register 0 |
| aux_hi1 | input | 16 | High word of auxiliary register 1 |
| wr_en | output | 1 | Write strobe for an accumulator middle word |
| wr_dst | output | 1 | Accumulator selected for the write |
| wr_data | output | 16 | Value to write |
| flags | output | 4 | Status: [3] sign, [2] zero, [1] overflow, [0] carry |
| ext_valid | output | 1 | Extension field is valid |
| ext_field | output | 7 | Extension bits of the executed instruction |

## Verification
The bench builds the unit with its default parameters: a 16-bit data word and a 7-bit extension field. At these values the sign and zero boundaries (0x0000, 0x8000, 0xFFFF) are reachable with directed operands. Bit 7, the bit that separates the logic opcodes from the shift opcodes, also sits directly above the extension field, so the bench can check that extension bits never alter decoding. Both settings of the destination and source select bits are driven for every operation, including an operand pair that cancels to zero.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

  localparam int INSN_W   = 16;
  localparam int FLAG_W   = 4;
  localparam int FLAG_C   = 0;
  localparam int FLAG_V   = 1;
  localparam int FLAG_Z   = 2;
  localparam int FLAG_S   = 3;
  localparam logic [3:0] GROUP_NIB = 4'h3;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_XOR_AUX,
    OP_AND_AUX,
    OP_OR_AUX,
    OP_AND_ACC,
    OP_OR_ACC,
    OP_XOR_ACC,
    OP_INV
  } mwl_op_e;

  typedef struct packed {
    mwl_op_e op;
    logic    dst;
    logic    src;
  } mwl_dec_t;

endpackage

// File: rtl/mwl_decode.sv
module mwl_decode
  import mwl_pkg::*;
(
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn,
  output mwl_dec_t          dec,
  output logic              hit
);

  always_comb begin
    dec.op  = OP_NONE;
    dec.dst = insn[8];
    dec.src = insn[9];
    if (insn[15:12] == GROUP_NIB) begin
      if (!insn[7]) begin
        unique case (insn[11:10])
          2'b00:   dec.op = OP_XOR_AUX;
          2'b01:   dec.op = OP_AND_AUX;
          2'b10:   dec.op = OP_OR_AUX;
          default: dec.op = insn[9] ? OP_OR_ACC : OP_AND_ACC;
        endcase
      end else if (insn[11:10] == 2'b00) begin
        dec.op = insn[9] ? OP_INV : OP_XOR_ACC;
      end
    end
  end

  assign hit = insn_valid && (dec.op != OP_NONE);

endmodule

// File: rtl/mwl_logic_alu.sv
module mwl_logic_alu
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  mwl_op_e           op,
  input  logic [DATA_W-1:0] dst_word,
  input  logic [DATA_W-1:0] aux_word,
  input  logic [DATA_W-1:0] peer_word,
  output logic [DATA_W-1:0] res
);

  function automatic logic [DATA_W-1:0] logic_op(
    input mwl_op_e           o,
    input logic [DATA_W-1:0] d,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] p
  );
    case (o)
      OP_XOR_AUX: return d ^ x;
      OP_AND_AUX: return d & x;
      OP_OR_AUX:  return d | x;
      OP_AND_ACC: return d & p;
      OP_OR_ACC:  return d | p;
      OP_XOR_ACC: return d ^ p;
      OP_INV:     return ~d;
      default:    return d;
    endcase
  endfunction

  assign res = logic_op(op, dst_word, aux_word, peer_word);

endmodule

// File: rtl/mwl_flag_gen.sv
module mwl_flag_gen
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);

  function automatic logic [FLAG_W-1:0] word_flags(input logic [DATA_W-1:0] w);
    logic [FLAG_W-1:0] f;
    f         = '0;
    f[FLAG_Z] = (w == '0);
    f[FLAG_S] = w[DATA_W-1];
    return f;
  endfunction

  assign flags = word_flags(res);

endmodule

// File: rtl/mwl_top.sv
module mwl_top
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 7
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [15:0]       insn,
  input  logic [DATA_W-1:0] acc_mid0,
  input  logic [DATA_W-1:0] acc_mid1,
  input  logic [DATA_W-1:0] aux_hi0,
  input  logic [DATA_W-1:0] aux_hi1,
  output logic              wr_en,
  output logic              wr_dst,
  output logic [DATA_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags,
  output logic              ext_valid,
  output logic [EXT_W-1:0]  ext_field
);

  localparam int ACC_N = 2;

  mwl_dec_t          dec;
  logic              op_hit;
  logic [DATA_W-1:0] acc_arr [ACC_N];
  logic [DATA_W-1:0] aux_arr [ACC_N];
  logic [DATA_W-1:0] dst_word;
  logic [DATA_W-1:0] peer_word;
  logic [DATA_W-1:0] aux_word;
  logic [DATA_W-1:0] alu_res;
  logic [FLAG_W-1:0] next_flags;

  assign acc_arr[0] = acc_mid0;
  assign acc_arr[1] = acc_mid1;
  assign aux_arr[0] = aux_hi0;
  assign aux_arr[1] = aux_hi1;

  mwl_decode u_dec (
    .insn_valid (insn_valid),
    .insn       (insn),
    .dec        (dec),
    .hit        (op_hit)
  );

  assign dst_word  = acc_arr[dec.dst];
  assign peer_word = acc_arr[~dec.dst];
  assign aux_word  = aux_arr[dec.src];

  mwl_logic_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (dec.op),
    .dst_word  (dst_word),
    .aux_word  (aux_word),
    .peer_word (peer_word),
    .res       (alu_res)
  );

  mwl_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res   (alu_res),
    .flags (next_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_dst    <= 1'b0;
      wr_data   <= '0;
      flags     <= '0;
      ext_valid <= 1'b0;
      ext_field <= '0;
    end else begin
      wr_en     <= op_hit;
      ext_valid <= op_hit;
      if (op_hit) begin
        wr_dst    <= dec.dst;
        wr_data   <= alu_res;
        flags     <= next_flags;
        ext_field <= insn[EXT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mwl_checker.sv
module mwl_checker
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 7
)(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic [15:0]       insn,
  input logic [DATA_W-1:0] acc_mid0,
  input logic [DATA_W-1:0] acc_mid1,
  input logic [DATA_W-1:0] aux_hi0,
  input logic [DATA_W-1:0] aux_hi1,
  input logic              op_hit,
  input logic              wr_en,
  input logic              wr_dst,
  input logic [DATA_W-1:0] wr_data,
  input logic [FLAG_W-1:0] flags,
  input logic              ext_valid,
  input logic [EXT_W-1:0]  ext_field
);

  assert_xor_aux_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:10] == 6'b001100 && !insn[7]) |=>
      (wr_en && wr_data == ($past(insn[8] ? acc_mid1 : acc_mid0) ^
                            $past(insn[9] ? aux_hi1 : aux_hi0))));

  assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:9] == 7'b0011001 && insn[7]) |=>
      (wr_en && wr_data == ~$past(insn[8] ? acc_mid1 : acc_mid0)));

  assert_dst_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_hit |=> (wr_en && wr_dst == $past(insn[8])));

  assert_cv_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flags[FLAG_C] == 1'b0 && flags[FLAG_V] == 1'b0));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flags[FLAG_Z] == (wr_data == '0)));

  assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flags[FLAG_S] == wr_data[DATA_W-1]));

  assert_ext_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (wr_en && ext_field == $past(insn[EXT_W-1:0])));

  assert_other_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:12] != 4'h3) |=> (!wr_en && !ext_valid && $stable(flags)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!wr_en && !ext_valid && $stable(flags)));

endmodule

bind mwl_top mwl_checker #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .acc_mid0   (acc_mid0),
  .acc_mid1   (acc_mid1),
  .aux_hi0    (aux_hi0),
  .aux_hi1    (aux_hi1),
  .op_hit     (op_hit),
  .wr_en      (wr_en),
  .wr_dst     (wr_dst),
  .wr_data    (wr_data),
  .flags      (flags),
  .ext_valid  (ext_valid),
  .ext_field  (ext_field)
);

// File: tb/mwl_top_tb.sv
`timescale 1ns/1ps
module mwl_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic [15:0] acc_mid0 = '0, acc_mid1 = '0, aux_hi0 = '0, aux_hi1 = '0;
  logic        wr_en, wr_dst, ext_valid;
  logic [15:0] wr_data;
  logic [3:0]  flags;
  logic [6:0]  ext_field;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [3:0] model_flags = 4'h0;

  always #2.5 clk = ~clk;

  mwl_top u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .acc_mid0(acc_mid0), .acc_mid1(acc_mid1), .aux_hi0(aux_hi0), .aux_hi1(aux_hi1),
    .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data), .flags(flags),
    .ext_valid(ext_valid), .ext_field(ext_field)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic [15:0] i, input logic [15:0] a0, a1, x0, x1,
                       output bit exec, output logic [15:0] r);
    logic [15:0] me, other, ax;
    me    = i[8] ? a1 : a0;
    other = i[8] ? a0 : a1;
    ax    = i[9] ? x1 : x0;
    exec  = 1'b1;
    r     = 16'h0;
    if (i[15:12] != 4'b0011) exec = 1'b0;
    else if (i[7] == 1'b1) begin
      if (i[11:9] == 3'b000)      r = me ^ other;
      else if (i[11:9] == 3'b001) r = me ^ 16'hFFFF;
      else                        exec = 1'b0;
    end else begin
      case (i[11:10])
        2'b00: r = me ^ ax;
        2'b01: r = me & ax;
        2'b10: r = me | ax;
        2'b11: r = i[9] ? (me | other) : (me & other);
      endcase
    end
  endtask

  task automatic run_op(input string req, input logic [15:0] i,
                        input logic [15:0] a0, a1, x0, x1, input bit valid = 1'b1);
    bit exec;
    logic [15:0] r;
    model(i, a0, a1, x0, x1, exec, r);
    exec = exec && valid;
    @(negedge clk);
    insn = i; acc_mid0 = a0; acc_mid1 = a1; aux_hi0 = x0; aux_hi1 = x1;
    insn_valid = valid;
    @(negedge clk);
    insn_valid = 1'b0;
    check_eq(req, "wr_en", wr_en, exec);
    check_eq(req, "ext_valid", ext_valid, exec);
    if (exec) begin
      model_flags = {r[15], (r == 16'h0), 1'b0, 1'b0};
      check_eq(req, "wr_data", wr_data, r);
      check_eq(req, "wr_dst", wr_dst, i[8]);
      check_eq(req, "ext_field", ext_field, i[6:0]);
    end
    check_eq(req, "flags", flags, model_flags);
  endtask

  task automatic t_reset();
    check_eq("R10", "wr_en", wr_en, 0);
    check_eq("R10", "wr_dst", wr_dst, 0);
    check_eq("R10", "wr_data", wr_data, 0);
    check_eq("R10", "flags", flags, 0);
    check_eq("R10", "ext_valid", ext_valid, 0);
    check_eq("R10", "ext_field", ext_field, 0);
  endtask

  task automatic t_xor_aux();
    run_op("R1", 16'h3000, 16'h1234, 16'h5678, 16'h00FF, 16'hFF00);
    run_op("R1", 16'h3125, 16'h1234, 16'h5678, 16'h00FF, 16'hFF00);
    run_op("R1", 16'h327F, 16'h1234, 16'h5678, 16'h00FF, 16'hFF00);
    run_op("R1", 16'h3301, 16'h1234, 16'hFF00, 16'h00FF, 16'hFF00);
  endtask

  task automatic t_and_or_aux();
    run_op("R2", 16'h3400, 16'hF0F0, 16'h0F0F, 16'hFF00, 16'h00FF);
    run_op("R2", 16'h3711, 16'hF0F0, 16'h0F0F, 16'hFF00, 16'h00FF);
    run_op("R2", 16'h3822, 16'h0001, 16'h0F0F, 16'h8000, 16'h00FF);
    run_op("R2", 16'h3B33, 16'hF0F0, 16'h0000, 16'hFF00, 16'h0000);
  endtask

  task automatic t_acc_pair();
    run_op("R3", 16'h3C05, 16'hAAAA, 16'h5555, 16'h1111, 16'h2222);
    run_op("R3", 16'h3D06, 16'hAAAF, 16'h555F, 16'h1111, 16'h2222);
    run_op("R3", 16'h3E07, 16'hAAAA, 16'h5555, 16'h1111, 16'h2222);
    run_op("R3", 16'h3F08, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_xor_acc();
    run_op("R4", 16'h3080, 16'h1357, 16'h2468, 16'h0000, 16'h0000);
    run_op("R4", 16'h31C3, 16'hBEEF, 16'hBEEF, 16'h1234, 16'h4321);
  endtask

  task automatic t_invert();
    run_op("R5", 16'h3280, 16'h0000, 16'h1234, 16'h5555, 16'h5555);
    run_op("R5", 16'h33FF, 16'h1234, 16'hFFFF, 16'h5555, 16'h5555);
  endtask

  task automatic t_flags();
    run_op("R7", 16'h3800, 16'h0000, 16'h0000, 16'h8000, 16'h0000);
    run_op("R7", 16'h3400, 16'h00FF, 16'h0000, 16'hFF00, 16'h0000);
    run_op("R7", 16'h3800, 16'h0001, 16'h0000, 16'h0100, 16'h0000);
  endtask

  task automatic t_ignored();
    run_op("R9", 16'h3280, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h3480, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h3A81, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h3CC0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h3F80, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_op("R9", 16'h2000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
  endtask

  task automatic t_idle();
    run_op("R11", 16'h3280, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000);
    run_op("R11", 16'h3000, 16'h1234, 16'h0000, 16'h1234, 16'h0000, 1'b0);
    run_op("R11", 16'h3280, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xor_aux();
    t_and_or_aux();
    t_acc_pair();
    t_xor_acc();
    t_invert();
    t_flags();
    t_ignored();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule